// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor Table

This block holds a direct-mapped array of small saturating counters that guess whether a conditional branch will be taken. A fetch stage presents an instruction address on the lookup side. In the same cycle it receives a taken or not-taken guess. Once the branch resolves, the execute side presents the branch address and the real outcome, and the selected entry is moved on the next clock edge.

No tag is kept. Every branch whose address bits 11 down to 2 agree shares one entry, whatever its upper bits are.

A build parameter selects the entry kind:
- **Two-bit hysteresis counter.** A strong state survives one wrong guess.
- **One-bit store.** It holds the most recent outcome only.

Top module: `bp_table`

## Requirements
- R1: The entry index is address bits [11:2], which gives 1024 entries. Bits [1:0] and all bits above 11 have no effect on which entry is read or written.
- R2: After reset every entry predicts not taken. In two-bit mode each counter holds 01, so a single taken update makes that entry predict taken. In one-bit mode each entry holds 0.
- R3: In two-bit mode the guess is the counter's upper bit: 11 and 10 give taken (lkp_taken_o=1), and 01 and 00 give not taken (lkp_taken_o=0).
- R4: In two-bit mode a taken update adds one to the counter and holds it at 11.
- R5: In two-bit mode a not-taken update subtracts one from the counter and holds it at 00. It never wraps.
- R6: In two-bit mode an entry at 11 still predicts taken after one not-taken update. It predicts not taken only after a second one.
- R7: In one-bit mode each update stores the outcome (1 for taken), and the guess equals the stored bit.
- R8: When a lookup and an update select the same entry in one cycle, the lookup returns the value from before the update. The new value is seen from the next cycle.
- R9: While upd_en_i is low, no entry changes, whatever the values on upd_pc_i and upd_taken_i.
- R10: A warm loop branch taken nine times and then not taken once is guessed wrong twice per pass in one-bit mode and once per pass in two-bit mode.
- R11: The address 0x1a305ff8 selects entry 0x3FE, the same entry as address 0x00000ff8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_pc_i | input | PC_W | Fetch address to predict |
| lkp_taken_o | output | 1 | Combinational guess, 1 = taken |
| upd_en_i | input | 1 | Write the resolved outcome this cycle |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The embedded properties watch every cycle for the following:
- the one-step counter moves and the holds at both ends (R4, R5);
- the stored outcome in one-bit mode (R7);
- the freeze of the whole array while updates are off (R9).

Some behaviours only the directed scenarios can show:
- which address bits select an entry, including the aliasing;
- the read-before-write order within one cycle;
- the two-miss flip from a strong state;
- the miss count per loop pass.

The bench reaches these through the guess output alone.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {
    MODE_ONE_BIT = 1'b0,
    MODE_TWO_BIT = 1'b1
  } bp_mode_e;

  function automatic int unsigned ctr_width(bp_mode_e mode);
    return (mode == MODE_TWO_BIT) ? 2 : 1;
  endfunction
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 10
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned LSB = 2;
  localparam int unsigned MSB = IDX_W + LSB - 1;

  // byte offset and high bits do not take part (untagged, word aligned)
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc_i[PC_W-1:MSB+1], pc_i[LSB-1:0]};

  assign idx_o = pc_i[MSB:LSB];
endmodule

// File: rtl/bp_ctr_next.sv
module bp_ctr_next #(
  parameter int unsigned CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur_i,
  input  logic             taken_i,
  output logic [CTR_W-1:0] nxt_o
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  generate
    if (CTR_W == 1) begin : g_last
      logic unused_cur;
      assign unused_cur = cur_i[0];
      assign nxt_o = taken_i;
    end else begin : g_sat
      always_comb begin
        nxt_o = cur_i;
        if (taken_i && cur_i != CTR_MAX)       nxt_o = cur_i + CTR_W'(1);
        else if (!taken_i && cur_i != CTR_MIN) nxt_o = cur_i - CTR_W'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/bp_table.sv
module bp_table #(
  parameter int unsigned       PC_W  = 32,
  parameter int unsigned       IDX_W = 10,
  parameter bp_pkg::bp_mode_e  MODE  = bp_pkg::MODE_TWO_BIT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lkp_pc_i,
  output logic            lkp_taken_o,
  input  logic            upd_en_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned CTR_W   = bp_pkg::ctr_width(MODE);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;
  // weakly not taken in two-bit mode, 0 in one-bit mode
  localparam logic [CTR_W-1:0] CTR_RST = (CTR_W > 1) ? CTR_W'(1) : '0;

  logic [ENTRIES-1:0][CTR_W-1:0] ctr_q;
  logic [IDX_W-1:0] lkp_idx, upd_idx;
  logic [CTR_W-1:0] upd_cur, upd_nxt;

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) lkp_idx_i (.pc_i(lkp_pc_i), .idx_o(lkp_idx));
  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W)) upd_idx_i (.pc_i(upd_pc_i), .idx_o(upd_idx));

  assign upd_cur = ctr_q[upd_idx];

  bp_ctr_next #(.CTR_W(CTR_W)) ctr_next_i (
    .cur_i  (upd_cur),
    .taken_i(upd_taken_i),
    .nxt_o  (upd_nxt)
  );

  // read side sees registered state: same-cycle update is not forwarded
  assign lkp_taken_o = ctr_q[lkp_idx][CTR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctr_q <= {ENTRIES{CTR_RST}};
    else if (upd_en_i) ctr_q[upd_idx] <= upd_nxt;
  end

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> ctr_q == $past(ctr_q));

  generate
    if (CTR_W > 1) begin : g_chk_sat
      // R4
      step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_en_i && upd_taken_i && upd_cur != CTR_MAX)
        |=> ctr_q[$past(upd_idx)] == $past(upd_cur) + CTR_W'(1));
      // R4
      sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_en_i && upd_taken_i && upd_cur == CTR_MAX)
        |=> ctr_q[$past(upd_idx)] == CTR_MAX);
      // R5
      step_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_en_i && !upd_taken_i && upd_cur != CTR_MIN)
        |=> ctr_q[$past(upd_idx)] == $past(upd_cur) - CTR_W'(1));
      // R5
      sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_en_i && !upd_taken_i && upd_cur == CTR_MIN)
        |=> ctr_q[$past(upd_idx)] == CTR_MIN);
    end else begin : g_chk_last
      // R7
      last_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_en_i |=> ctr_q[$past(upd_idx)] == CTR_W'($past(upd_taken_i)));
    end
  endgenerate
endmodule

// File: tb/bp_table_tb.sv
`timescale 1ns/1ps
module bp_table_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lkp_pc = '0, upd_pc = '0;
  logic        upd_en = 1'b0, upd_taken = 1'b0;
  logic        p2, p1;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  bp_table #(.MODE(bp_pkg::MODE_TWO_BIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lkp_pc_i(lkp_pc), .lkp_taken_o(p2),
    .upd_en_i(upd_en), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken));

  bp_table #(.MODE(bp_pkg::MODE_ONE_BIT)) dut1_i (
    .clk_i(clk), .rst_ni(rst_n), .lkp_pc_i(lkp_pc), .lkp_taken_o(p1),
    .upd_en_i(upd_en), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_both(input logic [31:0] pc, input bit e2, input bit e1, input string req);
    @(negedge clk);
    upd_en = 1'b0;
    lkp_pc = pc;
    #1;
    check(p2 == e2, {req, " two-bit"}, p2, e2);
    check(p1 == e1, {req, " one-bit"}, p1, e1);
  endtask

  task automatic update(input logic [31:0] pc, input bit t);
    @(negedge clk);
    upd_en = 1'b1; upd_pc = pc; upd_taken = t;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  // R2
  task automatic t_reset();
    expect_both(32'h0000_0000, 0, 0, "R2 reset");
    expect_both(32'h0000_0ffc, 0, 0, "R2 reset");
    update(32'h0000_0100, 1);
    expect_both(32'h0000_0100, 1, 1, "R2 one taken from weak");
  endtask

  // R3 R4 R5 R6 R7
  task automatic t_counter();
    logic [31:0] a = 32'h0000_0200;
    update(a, 1); update(a, 1); update(a, 1);
    expect_both(a, 1, 1, "R4 saturate at 11");
    update(a, 0);
    expect_both(a, 1, 0, "R6 first miss keeps taken / R7 last outcome");
    update(a, 0);
    expect_both(a, 0, 0, "R6 second miss flips / R3 01 not taken");
    update(a, 1);
    expect_both(a, 1, 1, "R3 10 predicts taken / R7");
    update(a, 0); update(a, 0); update(a, 0); update(a, 0);
    update(a, 1);
    expect_both(a, 0, 1, "R5 saturate at 00, no wrap / R7");
  endtask

  // R1 R11
  task automatic t_alias();
    update(32'h1a30_5ff8, 1);
    expect_both(32'h0000_0ff8, 1, 1, "R11 alias to entry 0x3FE");
    expect_both(32'hffff_fffb, 1, 1, "R1 low and high bits ignored");
    expect_both(32'h0000_0ff4, 0, 0, "R1 neighbour entry 0x3FD untouched");
    update(32'h0000_0ff9, 0);
    expect_both(32'h1a30_5ff8, 0, 0, "R1 write through offset address");
  endtask

  // R9
  task automatic t_hold();
    @(negedge clk);
    upd_en = 1'b0; upd_pc = 32'h0000_0300; upd_taken = 1'b1;
    repeat (4) @(negedge clk);
    expect_both(32'h0000_0300, 0, 0, "R9 disabled update ignored");
  endtask

  // R8
  task automatic t_same_cycle();
    @(negedge clk);
    lkp_pc = 32'h0000_0400;
    upd_en = 1'b1; upd_pc = 32'h0000_0400; upd_taken = 1'b1;
    #1;
    check(p2 == 1'b0, "R8 pre-update value two-bit", p2, 0);
    check(p1 == 1'b0, "R8 pre-update value one-bit", p1, 0);
    @(negedge clk);
    upd_en = 1'b0;
    #1;
    check(p2 == 1'b1, "R8 new value next cycle two-bit", p2, 1);
    check(p1 == 1'b1, "R8 new value next cycle one-bit", p1, 1);
  endtask

  // R10
  task automatic t_loop();
    logic [31:0] b = 32'h0000_0500;
    int m2, m1;
    for (int pass = 0; pass < 3; pass++) begin
      m2 = 0; m1 = 0;
      for (int it = 0; it < 10; it++) begin
        bit outc = (it < 9);
        @(negedge clk);
        lkp_pc = b; upd_en = 1'b1; upd_pc = b; upd_taken = outc;
        #1;
        if (p2 != outc) m2++;
        if (p1 != outc) m1++;
      end
      @(negedge clk);
      upd_en = 1'b0;
      if (pass > 0) begin
        check(m2 == 1, "R10 two-bit misses per pass", m2, 1);
        check(m1 == 2, "R10 one-bit misses per pass", m1, 2);
      end
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_counter();
    t_alias();
    t_hold();
    t_same_cycle();
    t_loop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule